// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from client logic, formats each one as a fixed eight-dword vector, and stores the vector in a circular buffer held in on-chip memory. A consumer drains the buffer through a dword read port and reports its progress by writing a byte-addressed read pointer. The block publishes its own byte-addressed write pointer, with a sticky overflow flag in bit 0, and drives an interrupt line while unread work exists.

The ring length can be changed at run time through a log2 size control. When the ring fills, the control bits choose one of three policies. Overwrite mode keeps writing and flags the overrun. Stall mode holds the event handshake off until the consumer frees a slot. Drop mode accepts the event and discards it. Turning the ring off returns both pointers and the flag to zero.

Top module: `ivr_ring_writer`

## Requirements
- R1: Dword 0 of a vector holds the client id in bits 7:0, source id in 15:8, ring id in 23:16, VMID in 27:24, the VMID-source flag in bit 31 and zeros in bits 30:28.
- R2: Dword 1 holds timestamp bits 31:0. Dword 2 holds timestamp bits 47:32 in bits 15:0 and the timestamp-source flag in bit 31. Dword 3 holds the PASID in bits 15:0 and the PASID-source flag in bit 31. Dwords 4 to 7 hold source-data words 0 to 3 (data word i is evt_data bits 32i+31:32i). Every bit not named is zero. The timestamp is the value present in the cycle the event is accepted.
- R3: wptr_word carries the byte write pointer in bits PTR_W-1:1 with bits 4:1 always zero, the overflow flag in bit 0, and zeros above. Each stored vector advances the pointer by 32 modulo the ring length of 4·2^size bytes. size_log2 is clamped to the range MIN_LOG2_DW..MAX_LOG2_DW.
- R4: The ring is full when (wptr+32) mod length equals the read pointer. With ovf_en=0 and drain_en=0, an event offered to a full ring is accepted (evt_ready=1), but neither the memory nor the write pointer changes.
- R5: With ovf_en=0 and drain_en=1, evt_ready is low while the ring is full and returns high once a read-pointer write frees a slot.
- R6: With ovf_en=1, whatever drain_en is, an event offered to a full ring is still stored, the pointer advances, and wptr_word bit 0 is set. The flag remains set across later writes.
- R7: A cycle with ovf_clr high clears the overflow flag, unless an overrun happens in the same cycle.
- R8: While ring_en is low, evt_ready is low, irq is low, both pointers and the flag are zero from the next cycle onward, and read-pointer writes are ignored.
- R9: irq is high exactly when ring_en and int_en are both high and either the pointers differ or the overflow flag is set.
- R10: mem_rd_data returns the dword at dword index mem_rd_addr (byte pointer divided by 4) one cycle after the address is presented.
- R11: A read-pointer write stores rptr_wdata masked to the ring length and rounded down to a multiple of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_en | input | 1 | Ring enable; low clears pointers and flag |
| int_en | input | 1 | Interrupt output enable |
| ovf_en | input | 1 | Overwrite-on-full policy |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| drain_en | input | 1 | Stall-on-full policy when ovf_en is low |
| size_log2 | input | SZ_W | log2 of the ring length in dwords |
| ts | input | 48 | Free-running timestamp |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event taken this cycle when valid |
| evt_client | input | 8 | Client id |
| evt_src | input | 8 | Source id |
| evt_ring | input | 8 | Ring id |
| evt_vmid | input | 4 | VMID |
| evt_vmid_src | input | 1 | VMID-source flag |
| evt_ts_src | input | 1 | Timestamp-source flag |
| evt_pasid | input | 16 | PASID |
| evt_pasid_src | input | 1 | PASID-source flag |
| evt_data | input | 128 | Four source-data words |
| rptr_wr | input | 1 | Read-pointer write strobe |
| rptr_wdata | input | PTR_W | New byte read pointer |
| wptr_word | output | 32 | Write pointer with overflow in bit 0 |
| mem_rd_addr | input | MAX_LOG2_DW | Dword read address |
| mem_rd_data | output | 32 | Read data, one cycle latency |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a ring that is exactly full. Only there do the three full-ring policies differ, and only there can the overflow flag be set while the two pointers are equal. The bench reaches it on a four-slot ring by storing three vectors without moving the read pointer. It then visits drop, stall and overwrite in turn from that same state, and moves the read pointer one slot at a time between them. A full sweep over every slot of every ring size, including two laps of wrap, checks all eight dwords of each stored vector.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int VEC_DW    = 8;
   localparam int VEC_BYTES = 32;

   typedef struct packed {
      logic [7:0]       client;
      logic [7:0]       src;
      logic [7:0]       ring;
      logic [3:0]       vmid;
      logic             vmid_src;
      logic [47:0]      ts;
      logic             ts_src;
      logic [15:0]      pasid;
      logic             pasid_src;
      logic [3:0][31:0] data;
   } ivr_event_t;

   typedef logic [VEC_DW-1:0][31:0] ivr_vec_t;

   typedef enum logic [1:0] {
      FULL_DROP      = 2'd0,
      FULL_STALL     = 2'd1,
      FULL_OVERWRITE = 2'd2
   } ivr_full_mode_e;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
   import ivr_pkg::*;
(
   input  ivr_event_t ev,
   output ivr_vec_t   vec
);
   always_comb begin
      vec[0] = {ev.vmid_src, 3'b000, ev.vmid, ev.ring, ev.src, ev.client};
      vec[1] = ev.ts[31:0];
      vec[2] = {ev.ts_src, 15'd0, ev.ts[47:32]};
      vec[3] = {ev.pasid_src, 15'd0, ev.pasid};
   end

   for (genvar gi = 0; gi < 4; gi++) begin : g_data
      assign vec[4+gi] = ev.data[gi];
   end
endmodule

// File: rtl/ivr_ram.sv
module ivr_ram
   import ivr_pkg::*;
#(
   parameter int SLOT_W = 5,
   parameter bit RD_REG = 1'b1,
   localparam int SLOTS = 1 << SLOT_W,
   localparam int ADDR_W = SLOT_W + 3
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SLOT_W-1:0] wslot,
   input  ivr_vec_t          wvec,
   input  logic [ADDR_W-1:0] raddr,
   output logic [31:0]       rdata
);
   ivr_vec_t mem [SLOTS];
   logic [31:0] rd_word;

   always_ff @(posedge clk) begin
      if (we) mem[wslot] <= wvec;
   end

   assign rd_word = mem[raddr[ADDR_W-1:3]][raddr[2:0]];

   if (RD_REG) begin : g_rd_reg
      logic [31:0] rdata_q;
      always_ff @(posedge clk) rdata_q <= rd_word;
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = rd_word;
   end
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
   import ivr_pkg::*;
#(
   parameter int MAX_LOG2_DW = 8,
   parameter int MIN_LOG2_DW = 4,
   localparam int PTR_W = MAX_LOG2_DW + 2,
   localparam int SZ_W  = $clog2(MAX_LOG2_DW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ring_en,
   input  logic             int_en,
   input  logic             ovf_en,
   input  logic             ovf_clr,
   input  logic             drain_en,
   input  logic [SZ_W-1:0]  size_log2,
   input  logic             evt_valid,
   output logic             evt_ready,
   input  logic             rptr_wr,
   input  logic [PTR_W-1:0] rptr_wdata,
   output logic             wr_en,
   output logic [PTR_W-1:0] wptr,
   output logic             ovf,
   output logic             irq
);
   localparam logic [PTR_W-1:0] ALIGN = {{(PTR_W-5){1'b1}}, 5'b00000};
   localparam logic [PTR_W-1:0] STEP  = PTR_W'(VEC_BYTES);

   logic [SZ_W-1:0]  size_eff;
   logic [PTR_W-1:0] mask, wnext, rptr;
   logic             full, accept, overrun;
   ivr_full_mode_e   mode;

   always_comb begin
      if (size_log2 < SZ_W'(MIN_LOG2_DW))      size_eff = SZ_W'(MIN_LOG2_DW);
      else if (size_log2 > SZ_W'(MAX_LOG2_DW)) size_eff = SZ_W'(MAX_LOG2_DW);
      else                                     size_eff = size_log2;
   end

   assign mask  = {PTR_W{1'b1}} >> (SZ_W'(MAX_LOG2_DW) - size_eff);
   assign wnext = (wptr + STEP) & mask;
   assign full  = (wnext == rptr);

   always_comb begin
      if (ovf_en)        mode = FULL_OVERWRITE;
      else if (drain_en) mode = FULL_STALL;
      else               mode = FULL_DROP;
   end

   assign evt_ready = ring_en && !(full && mode == FULL_STALL);
   assign accept    = evt_valid && evt_ready;
   assign wr_en     = accept && (!full || mode == FULL_OVERWRITE);
   assign overrun   = accept && full && mode == FULL_OVERWRITE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else if (!ring_en) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else begin
         if (wr_en)   wptr <= wnext;
         if (rptr_wr) rptr <= rptr_wdata & mask & ALIGN;
         if (overrun)      ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

   assign irq = ring_en && int_en && ((wptr != rptr) || ovf);

   // R3 R4 R5
   wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en && !wr_en) |=> (wptr == $past(wptr)));

   // R8
   disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ring_en |=> (wptr == '0 && rptr == '0 && !ovf));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en && ovf && !ovf_clr) |=> ovf);

   // R7
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en && ovf_clr && !overrun) |=> !ovf);

   // R3
   wptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wptr[4:0] == 5'd0 && wptr != $past(wptr)));
endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
   import ivr_pkg::*;
#(
   parameter int MAX_LOG2_DW = 8,
   parameter int MIN_LOG2_DW = 4,
   parameter bit RD_REG      = 1'b1,
   localparam int PTR_W  = MAX_LOG2_DW + 2,
   localparam int SZ_W   = $clog2(MAX_LOG2_DW + 1),
   localparam int SLOT_W = MAX_LOG2_DW - 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ring_en,
   input  logic                   int_en,
   input  logic                   ovf_en,
   input  logic                   ovf_clr,
   input  logic                   drain_en,
   input  logic [SZ_W-1:0]        size_log2,
   input  logic [47:0]            ts,
   input  logic                   evt_valid,
   output logic                   evt_ready,
   input  logic [7:0]             evt_client,
   input  logic [7:0]             evt_src,
   input  logic [7:0]             evt_ring,
   input  logic [3:0]             evt_vmid,
   input  logic                   evt_vmid_src,
   input  logic                   evt_ts_src,
   input  logic [15:0]            evt_pasid,
   input  logic                   evt_pasid_src,
   input  logic [127:0]           evt_data,
   input  logic                   rptr_wr,
   input  logic [PTR_W-1:0]       rptr_wdata,
   output logic [31:0]            wptr_word,
   input  logic [MAX_LOG2_DW-1:0] mem_rd_addr,
   output logic [31:0]            mem_rd_data,
   output logic                   irq
);
   if (MIN_LOG2_DW < 4 || MIN_LOG2_DW > MAX_LOG2_DW || MAX_LOG2_DW > 16) begin : g_bad_cfg
      $error("ivr_ring_writer: need 4 <= MIN_LOG2_DW <= MAX_LOG2_DW <= 16");
   end

   ivr_event_t       ev;
   ivr_vec_t         vec;
   logic             wr_en, ovf;
   logic [PTR_W-1:0] wptr;

   always_comb begin
      ev.client    = evt_client;
      ev.src       = evt_src;
      ev.ring      = evt_ring;
      ev.vmid      = evt_vmid;
      ev.vmid_src  = evt_vmid_src;
      ev.ts        = ts;
      ev.ts_src    = evt_ts_src;
      ev.pasid     = evt_pasid;
      ev.pasid_src = evt_pasid_src;
      for (int i = 0; i < 4; i++) ev.data[i] = evt_data[32*i +: 32];
   end

   ivr_pack u_pack (.ev(ev), .vec(vec));

   ivr_ptr #(.MAX_LOG2_DW(MAX_LOG2_DW), .MIN_LOG2_DW(MIN_LOG2_DW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_en   (ring_en),
      .int_en    (int_en),
      .ovf_en    (ovf_en),
      .ovf_clr   (ovf_clr),
      .drain_en  (drain_en),
      .size_log2 (size_log2),
      .evt_valid (evt_valid),
      .evt_ready (evt_ready),
      .rptr_wr   (rptr_wr),
      .rptr_wdata(rptr_wdata),
      .wr_en     (wr_en),
      .wptr      (wptr),
      .ovf       (ovf),
      .irq       (irq)
   );

   ivr_ram #(.SLOT_W(SLOT_W), .RD_REG(RD_REG)) u_ram (
      .clk  (clk),
      .we   (wr_en),
      .wslot(wptr[PTR_W-1:5]),
      .wvec (vec),
      .raddr(mem_rd_addr),
      .rdata(mem_rd_data)
   );

   assign wptr_word = {{(32-PTR_W){1'b0}}, wptr[PTR_W-1:1], ovf};
endmodule

// File: tb/ivr_ring_writer_bench.sv
module ivr_ring_writer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXL  = 6;
   localparam int MINL  = 4;
   localparam int PTR_W = MAXL + 2;
   localparam int SZ_W  = $clog2(MAXL + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ring_en = 0, int_en = 0, ovf_en = 0, ovf_clr = 0, drain_en = 0;
   logic [SZ_W-1:0] size_log2 = '0;
   logic [47:0] ts = '0;
   logic evt_valid = 0, evt_ready;
   logic [7:0] evt_client = 0, evt_src = 0, evt_ring = 0;
   logic [3:0] evt_vmid = 0;
   logic evt_vmid_src = 0, evt_ts_src = 0, evt_pasid_src = 0;
   logic [15:0] evt_pasid = 0;
   logic [127:0] evt_data = '0;
   logic rptr_wr = 0;
   logic [PTR_W-1:0] rptr_wdata = '0;
   logic [31:0] wptr_word;
   logic [MAXL-1:0] mem_rd_addr = '0;
   logic [31:0] mem_rd_data;
   logic irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ivr_ring_writer #(.MAX_LOG2_DW(MAXL), .MIN_LOG2_DW(MINL), .RD_REG(1'b1)) u_ivr_ring_writer (
      .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .int_en(int_en), .ovf_en(ovf_en),
      .ovf_clr(ovf_clr), .drain_en(drain_en), .size_log2(size_log2), .ts(ts),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_client(evt_client),
      .evt_src(evt_src), .evt_ring(evt_ring), .evt_vmid(evt_vmid),
      .evt_vmid_src(evt_vmid_src), .evt_ts_src(evt_ts_src), .evt_pasid(evt_pasid),
      .evt_pasid_src(evt_pasid_src), .evt_data(evt_data), .rptr_wr(rptr_wr),
      .rptr_wdata(rptr_wdata), .wptr_word(wptr_word), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // event field generators
   function automatic logic [31:0] f_client(int k); return 32'((k*3 + 1) & 8'hFF); endfunction
   function automatic logic [31:0] f_src(int k);    return 32'((k ^ 8'h5A) & 8'hFF); endfunction
   function automatic logic [31:0] f_ring(int k);   return 32'((k + 2) & 8'hFF); endfunction
   function automatic logic [31:0] f_vmid(int k);   return 32'(k & 15); endfunction
   function automatic logic [31:0] f_pasid(int k);  return 32'((16'h1000 + k*7) & 16'hFFFF); endfunction
   function automatic logic [47:0] f_ts(int k);     return 48'h8A5C_1234_5678 + 48'(k) * 48'd9973; endfunction
   function automatic logic [31:0] f_data(int k, int i); return 32'hD000_0000 + 32'(k*16 + i); endfunction

   // R1 R2 expected dword i of event k
   function automatic logic [31:0] exp_dw(int k, int i);
      logic [47:0] t;
      t = f_ts(k);
      case (i)
         0: return f_client(k) + (f_src(k) << 8) + (f_ring(k) << 16) + (f_vmid(k) << 24)
                   + (32'(k & 1) << 31);
         1: return t[31:0];
         2: return 32'(t >> 32) + (32'((k >> 1) & 1) << 31);
         3: return f_pasid(k) + (32'((k >> 2) & 1) << 31);
         default: return f_data(k, i - 4);
      endcase
   endfunction

   // offers event k for one cycle; returns ready seen before the edge
   task automatic send(input int k, output logic rdy);
      evt_client = 8'(f_client(k));
      evt_src = 8'(f_src(k));
      evt_ring = 8'(f_ring(k));
      evt_vmid = 4'(f_vmid(k));
      evt_vmid_src = k[0];
      evt_ts_src = k[1];
      evt_pasid_src = k[2];
      evt_pasid = 16'(f_pasid(k));
      ts = f_ts(k);
      for (int i = 0; i < 4; i++) evt_data[32*i +: 32] = f_data(k, i);
      evt_valid = 1'b1;
      #1;
      rdy = evt_ready;
      tick();
      evt_valid = 1'b0;
      ts = ts + 48'd1;
   endtask

   task automatic read_dw(input int addr, output logic [31:0] d);
      mem_rd_addr = MAXL'(addr);
      tick();
      d = mem_rd_data;
   endtask

   task automatic write_rptr(input int v);
      rptr_wr = 1'b1;
      rptr_wdata = PTR_W'(v);
      tick();
      rptr_wr = 1'b0;
   endtask

   task automatic restart(input int sz);
      ring_en = 1'b0;
      tick();
      size_log2 = SZ_W'(sz);
      ring_en = 1'b1;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic rdy;
      logic [31:0] d, saved;
      int w, k, bytes;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      #1;
      // R8 reset / disabled state
      check("R8 reset wptr", wptr_word, 32'd0);
      check("R8 reset irq", 32'(irq), 32'd0);
      check("R8 reset ready", 32'(evt_ready), 32'd0);

      int_en = 1'b1;
      k = 0;
      // R3 R1 R2 R10 R9: every slot of every size, two laps
      for (int sz = MINL; sz <= MAXL; sz++) begin
         restart(sz);
         bytes = 4 << sz;
         w = 0;
         check("R9 irq idle", 32'(irq), 32'd0);
         for (int n = 0; n < 2 * (bytes / 32); n++) begin
            send(k, rdy);
            check("R3 ready", 32'(rdy), 32'd1);
            check("R3 wptr step", wptr_word, 32'((w + 32) % bytes));
            check("R9 irq pending", 32'(irq), 32'd1);
            for (int i = 0; i < 8; i++) begin
               read_dw(w / 4 + i, d);
               check((i == 0) ? "R1 dword0" : "R2 R10 dword", d, exp_dw(k, i));
            end
            w = (w + 32) % bytes;
            write_rptr(w);
            #1;
            check("R9 irq cleared", 32'(irq), 32'd0);
            k++;
         end
      end

      // R4 drop mode on a four-slot ring
      restart(5);
      for (int n = 0; n < 3; n++) begin
         send(k, rdy);
         k++;
      end
      check("R4 wptr full", wptr_word, 32'd96);
      read_dw(24, saved);
      send(k, rdy);
      k++;
      check("R4 drop accepted", 32'(rdy), 32'd1);
      check("R4 drop wptr", wptr_word, 32'd96);
      read_dw(24, d);
      check("R4 drop memory", d, saved);
      int_en = 1'b0;
      #1;
      check("R9 int_en gate", 32'(irq), 32'd0);
      int_en = 1'b1;

      // R5 stall mode
      drain_en = 1'b1;
      #1;
      check("R5 stall ready", 32'(evt_ready), 32'd0);
      for (int n = 0; n < 3; n++) begin
         send(k, rdy);
         check("R5 stalled", 32'(rdy), 32'd0);
      end
      check("R5 stall wptr", wptr_word, 32'd96);
      write_rptr(32);
      #1;
      check("R5 ready after drain", 32'(evt_ready), 32'd1);
      send(k, rdy);
      k++;
      check("R5 wptr wrap", wptr_word, 32'd0);
      #1;
      check("R5 full again", 32'(evt_ready), 32'd0);

      // R6 overwrite mode (overrides stall)
      ovf_en = 1'b1;
      #1;
      check("R6 ready", 32'(evt_ready), 32'd1);
      send(k, rdy);
      k++;
      check("R6 overrun word", wptr_word, 32'd33);
      check("R9 irq on overflow with equal pointers", 32'(irq), 32'd1);
      send(k, rdy);
      k++;
      check("R6 sticky", wptr_word, 32'd65);
      ovf_clr = 1'b1;
      tick();
      ovf_clr = 1'b0;
      check("R7 clear", wptr_word, 32'd64);

      // R11 read pointer masking and alignment
      write_rptr(8'hFF);
      ovf_en = 1'b0;
      #1;
      check("R11 masked rptr makes ring full", 32'(evt_ready), 32'd0);
      write_rptr(8'h5F);
      #1;
      check("R11 aligned rptr equals wptr", 32'(irq), 32'd0);
      check("R11 ready", 32'(evt_ready), 32'd1);

      // R8 disable
      ring_en = 1'b0;
      #1;
      check("R8 ready off", 32'(evt_ready), 32'd0);
      check("R8 irq off", 32'(irq), 32'd0);
      tick();
      check("R8 wptr cleared", wptr_word, 32'd0);
      write_rptr(64);
      ring_en = 1'b1;
      #1;
      check("R8 rptr write ignored", 32'(irq), 32'd0);
      drain_en = 1'b0;

      // R3 size clamping
      restart(0);
      send(k, rdy);
      k++;
      write_rptr(32);
      send(k, rdy);
      k++;
      check("R3 clamp low wrap", wptr_word, 32'd0);
      restart(7);
      w = 0;
      for (int n = 0; n < 8; n++) begin
         send(k, rdy);
         k++;
         w = (w + 32) % 256;
         write_rptr(w);
         if (n == 6) check("R3 clamp high", wptr_word, 32'd224);
      end
      check("R3 clamp high wrap", wptr_word, 32'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule